// File: doc/BRIEF.md
# SPI Master Interrupt Status Unit

This block owns the interrupt state of a FIFO-based SPI master. It watches the occupancy counts and full flags of the transmit and receive FIFOs, together with single-cycle event pulses for transmit underflow, receive overflow and mode fault. From these it maintains a seven-bit status register. Three bits are sticky event latches. The other four are level bits, recomputed on every clock from the FIFO state and two programmable thresholds.

A small register bus reads and writes the status, the interrupt mask and the two thresholds. The mask has no direct write path. Software sets mask bits through one register and clears them through another, and can read the mask at a third. Reading the status register clears it. Writing ones to it clears the chosen sticky bits.

While the linear-read mode input is high, the status register and the interrupt line hold their values. The single interrupt output is a registered level: the OR of the masked status bits.

Top module: `spim_irq_unit`

## Requirements
- R1: After reset the status register and the mask read 0, both thresholds read 1, and `irq` is 0.
- R2: The sticky bits are bit 6 (tx underflow, from `ev_tx_under`), bit 1 (mode fault, from `ev_mode_fail`) and bit 0 (rx overflow, from `ev_rx_over`). A pulse sets its bit on the next clock, and the bit then holds until it is cleared.
- R3: Bit 5 follows `rx_full` and bit 3 follows `tx_full`, each one clock later.
- R4: Bit 4 is set when `rx_level` >= the rx threshold. Bit 2 is set when `tx_level` < the tx threshold. Both bits are recomputed every clock. The tx threshold is read and written at word offset 4, and the rx threshold at offset 5.
- R5: A read at offset 0 returns the status in bits 6..0, with the upper read bits zero, and clears every sticky bit. Level bits are recomputed on the following clock.
- R6: Writing offset 0 clears each sticky bit whose write-data bit is 1 and leaves the other sticky bits unchanged.
- R7: Writing offset 1 ORs write data bits 6..0 into the mask. Writing offset 2 clears the mask bits given as ones. Offset 3 returns the mask and ignores writes. Offsets 1 and 2 read 0.
- R8: `irq` equals the OR over bits 6..0 of (mask AND status) as they stood one clock earlier.
- R9: While `linear_mode` is 1, the status register and `irq` keep their values. Events, level changes and clears in that time are dropped. Mask and threshold writes still take effect.
- R10: A sticky event that arrives in the same cycle as a read-clear or a write-one-clear of its bit is kept, not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register word offset |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, valid in the cycle of the read strobe |
| tx_level | input | OCC_W | Transmit FIFO occupancy |
| rx_level | input | OCC_W | Receive FIFO occupancy |
| tx_full | input | 1 | Transmit FIFO full |
| rx_full | input | 1 | Receive FIFO full |
| ev_tx_under | input | 1 | Transmit underflow event pulse |
| ev_rx_over | input | 1 | Receive overflow event pulse |
| ev_mode_fail | input | 1 | Mode fault event pulse |
| linear_mode | input | 1 | Freezes the status register and the interrupt line |
| irq | output | 1 | Registered level interrupt |

## Verification
The bench probes both threshold comparisons at their exact boundaries. Occupancy equal to the rx threshold must set bit 4, and occupancy equal to the tx threshold must clear bit 2; a design that swapped the comparison or its strictness would get one of these wrong. It also fires an event in the same cycle as a status read. A design that let the clear win there would silently lose the event. It also checks that `irq` moves exactly one clock after the status or mask changes, and that a frozen interval drops events and clears instead of replaying them once linear mode ends.

// File: rtl/spim_irq_pkg.sv
package spim_irq_pkg;
  localparam int NSTAT = 7;

  // status bit positions (software decodes these)
  localparam int BIT_TX_UNDER  = 6;
  localparam int BIT_RX_FULL   = 5;
  localparam int BIT_RX_AVAIL  = 4;
  localparam int BIT_TX_FULL   = 3;
  localparam int BIT_TX_ROOM   = 2;
  localparam int BIT_MODE_FAIL = 1;
  localparam int BIT_RX_OVER   = 0;

  localparam logic [NSTAT-1:0] STICKY_BITS = 7'b100_0011;

  // register word offsets
  localparam int OFS_STATUS   = 0;
  localparam int OFS_MASK_SET = 1;
  localparam int OFS_MASK_CLR = 2;
  localparam int OFS_MASK     = 3;
  localparam int OFS_TX_THR   = 4;
  localparam int OFS_RX_THR   = 5;

  typedef logic [NSTAT-1:0] stat_vec_t;
endpackage

// File: rtl/spim_irq_regs.sv
module spim_irq_regs
  import spim_irq_pkg::*;
#(
  parameter int OCC_W  = 6,
  parameter int ADDR_W = 3,
  parameter int BUS_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output stat_vec_t         mask_q,
  output logic [OCC_W-1:0]  tx_thr_q,
  output logic [OCC_W-1:0]  rx_thr_q,
  output logic              stat_rd_clr,
  output stat_vec_t         stat_wr_clr
);
  localparam logic [OCC_W-1:0] THR_RESET = OCC_W'(1);

  logic      hit_status, hit_mset, hit_mclr, hit_txthr, hit_rxthr;
  logic      wr_acc, rd_acc;
  logic      mask_en, txthr_en, rxthr_en;
  stat_vec_t wr_bits;
  stat_vec_t mask_d;

  always_comb begin
    wr_acc     = bus_en & bus_we;
    rd_acc     = bus_en & ~bus_we;
    hit_status = (bus_addr == ADDR_W'(OFS_STATUS));
    hit_mset   = (bus_addr == ADDR_W'(OFS_MASK_SET));
    hit_mclr   = (bus_addr == ADDR_W'(OFS_MASK_CLR));
    hit_txthr  = (bus_addr == ADDR_W'(OFS_TX_THR));
    hit_rxthr  = (bus_addr == ADDR_W'(OFS_RX_THR));
    wr_bits    = bus_wdata[NSTAT-1:0];

    mask_en  = wr_acc & (hit_mset | hit_mclr);
    txthr_en = wr_acc & hit_txthr;
    rxthr_en = wr_acc & hit_rxthr;

    mask_d = mask_q;
    if (hit_mset) mask_d = mask_q | wr_bits;
    if (hit_mclr) mask_d = mask_q & ~wr_bits;

    stat_rd_clr = rd_acc & hit_status;
    stat_wr_clr = (wr_acc & hit_status) ? wr_bits : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      tx_thr_q <= THR_RESET;
      rx_thr_q <= THR_RESET;
    end else begin
      if (mask_en)  mask_q   <= mask_d;
      if (txthr_en) tx_thr_q <= bus_wdata[OCC_W-1:0];
      if (rxthr_en) rx_thr_q <= bus_wdata[OCC_W-1:0];
    end
  end
endmodule

// File: rtl/spim_irq_status.sv
module spim_irq_status
  import spim_irq_pkg::*;
#(
  parameter int OCC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [OCC_W-1:0] tx_level,
  input  logic [OCC_W-1:0] rx_level,
  input  logic             tx_full,
  input  logic             rx_full,
  input  logic             ev_tx_under,
  input  logic             ev_rx_over,
  input  logic             ev_mode_fail,
  input  logic [OCC_W-1:0] tx_thr,
  input  logic [OCC_W-1:0] rx_thr,
  input  logic             rd_clr,
  input  stat_vec_t        wr_clr,
  output stat_vec_t        status_q
);
  stat_vec_t src;
  stat_vec_t clr;
  stat_vec_t status_d;

  always_comb begin
    src                = '0;
    src[BIT_TX_UNDER]  = ev_tx_under;
    src[BIT_RX_FULL]   = rx_full;
    src[BIT_RX_AVAIL]  = (rx_level >= rx_thr);
    src[BIT_TX_FULL]   = tx_full;
    src[BIT_TX_ROOM]   = (tx_level < tx_thr);
    src[BIT_MODE_FAIL] = ev_mode_fail;
    src[BIT_RX_OVER]   = ev_rx_over;
    clr                = {NSTAT{rd_clr}} | wr_clr;
  end

  // sticky bits hold until cleared, a new event wins over a clear;
  // level bits take the fresh source value every cycle
  for (genvar i = 0; i < NSTAT; i++) begin : g_bit
    assign status_d[i] = src[i] | (STICKY_BITS[i] & status_q[i] & ~clr[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else if (upd_en) status_q <= status_d;
  end
endmodule

// File: rtl/spim_irq_line.sv
module spim_irq_line
  import spim_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      upd_en,
  input  stat_vec_t mask,
  input  stat_vec_t status,
  output logic      irq_q
);
  logic irq_d;

  always_comb irq_d = |(mask & status);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else if (upd_en) irq_q <= irq_d;
  end
endmodule

// File: rtl/spim_irq_unit.sv
module spim_irq_unit
  import spim_irq_pkg::*;
#(
  parameter int  FIFO_DEPTH = 32,
  parameter int  ADDR_W     = 3,
  localparam int OCC_W      = $clog2(FIFO_DEPTH + 1),
  localparam int BUS_W      = (OCC_W > NSTAT) ? OCC_W : NSTAT
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [OCC_W-1:0]  tx_level,
  input  logic [OCC_W-1:0]  rx_level,
  input  logic              tx_full,
  input  logic              rx_full,
  input  logic              ev_tx_under,
  input  logic              ev_rx_over,
  input  logic              ev_mode_fail,
  input  logic              linear_mode,
  output logic              irq
);
  logic [1:0]       rst_pipe;
  logic             rst_n;
  logic             upd_en;
  stat_vec_t        mask_q;
  stat_vec_t        status_q;
  stat_vec_t        stat_wr_clr;
  logic             stat_rd_clr;
  logic [OCC_W-1:0] tx_thr_q;
  logic [OCC_W-1:0] rx_thr_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_pipe <= '0;
    else rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n  = rst_pipe[1];
  assign upd_en = ~linear_mode;

  spim_irq_regs #(.OCC_W(OCC_W), .ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .mask_q     (mask_q),
    .tx_thr_q   (tx_thr_q),
    .rx_thr_q   (rx_thr_q),
    .stat_rd_clr(stat_rd_clr),
    .stat_wr_clr(stat_wr_clr)
  );

  spim_irq_status #(.OCC_W(OCC_W)) u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd_en      (upd_en),
    .tx_level    (tx_level),
    .rx_level    (rx_level),
    .tx_full     (tx_full),
    .rx_full     (rx_full),
    .ev_tx_under (ev_tx_under),
    .ev_rx_over  (ev_rx_over),
    .ev_mode_fail(ev_mode_fail),
    .tx_thr      (tx_thr_q),
    .rx_thr      (rx_thr_q),
    .rd_clr      (stat_rd_clr),
    .wr_clr      (stat_wr_clr),
    .status_q    (status_q)
  );

  spim_irq_line u_line (
    .clk   (clk),
    .rst_n (rst_n),
    .upd_en(upd_en),
    .mask  (mask_q),
    .status(status_q),
    .irq_q (irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (int'(bus_addr))
      OFS_STATUS: bus_rdata = BUS_W'(status_q);
      OFS_MASK:   bus_rdata = BUS_W'(mask_q);
      OFS_TX_THR: bus_rdata = BUS_W'(tx_thr_q);
      OFS_RX_THR: bus_rdata = BUS_W'(rx_thr_q);
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spim_irq_chk.sv
module spim_irq_chk
  import spim_irq_pkg::*;
#(
  parameter int OCC_W  = 6,
  parameter int ADDR_W = 3,
  parameter int BUS_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              linear_mode,
  input logic              ev_tx_under,
  input logic              ev_rx_over,
  input logic              ev_mode_fail,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [OCC_W-1:0]  rx_level,
  input logic [OCC_W-1:0]  rx_thr,
  input stat_vec_t         status,
  input stat_vec_t         mask,
  input logic              irq
);
  logic rd_stat, wr_mset, wr_mclr;
  stat_vec_t wbits;
  assign rd_stat = bus_en & ~bus_we & (bus_addr == ADDR_W'(OFS_STATUS));
  assign wr_mset = bus_en & bus_we & (bus_addr == ADDR_W'(OFS_MASK_SET));
  assign wr_mclr = bus_en & bus_we & (bus_addr == ADDR_W'(OFS_MASK_CLR));
  assign wbits   = bus_wdata[NSTAT-1:0];

  assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !linear_mode |=> (irq == $past(|(mask & status))));

  assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    linear_mode |=> ($stable(status) && $stable(irq)));

  assert_sticky_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_under && !linear_mode) |=> status[BIT_TX_UNDER]);

  assert_event_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_over && rd_stat && !linear_mode) |=> status[BIT_RX_OVER]);

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !linear_mode && !ev_mode_fail) |=> !status[BIT_MODE_FAIL]);

  assert_rx_threshold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !linear_mode |=> (status[BIT_RX_AVAIL] == ($past(rx_level) >= $past(rx_thr))));

  assert_mask_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mset |=> ((mask & $past(wbits)) == $past(wbits)));

  assert_mask_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mclr |=> ((mask & $past(wbits)) == '0));
endmodule

bind spim_irq_unit spim_irq_chk #(.OCC_W(OCC_W), .ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .linear_mode (linear_mode),
  .ev_tx_under (ev_tx_under),
  .ev_rx_over  (ev_rx_over),
  .ev_mode_fail(ev_mode_fail),
  .bus_en      (bus_en),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .rx_level    (rx_level),
  .rx_thr      (rx_thr_q),
  .status      (status_q),
  .mask        (mask_q),
  .irq         (irq)
);

// File: tb/spim_irq_unit_tb_top.sv
`timescale 1ns/100ps
module spim_irq_unit_tb_top;
  localparam int OCC_W = 6;
  localparam int BUS_W = 7;

  logic             clk = 1'b0;
  logic             arst_n = 1'b0;
  logic             b_en = 0, b_we = 0;
  logic [2:0]       b_addr = '0;
  logic [BUS_W-1:0] b_wdata = '0;
  logic [BUS_W-1:0] rdata;
  logic [OCC_W-1:0] tx_lvl = '0, rx_lvl = '0;
  logic             txf = 0, rxf = 0, e_un = 0, e_ov = 0, e_mf = 0, lin = 0;
  logic             irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spim_irq_unit dut_i (
    .clk(clk), .arst_n(arst_n), .bus_en(b_en), .bus_we(b_we), .bus_addr(b_addr),
    .bus_wdata(b_wdata), .bus_rdata(rdata), .tx_level(tx_lvl), .rx_level(rx_lvl),
    .tx_full(txf), .rx_full(rxf), .ev_tx_under(e_un), .ev_rx_over(e_ov),
    .ev_mode_fail(e_mf), .linear_mode(lin), .irq(irq)
  );

  // behavioural reference model
  int m_status, m_mask, m_txthr, m_rxthr, m_irq;
  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      m_status = 0; m_mask = 0; m_txthr = 1; m_rxthr = 1; m_irq = 0;
    end else begin
      if (!lin) begin
        int nst;
        m_irq = ((m_mask & m_status) != 0) ? 1 : 0;
        nst = m_status & 'h43;
        if (b_en && !b_we && b_addr == 0) nst = 0;
        if (b_en && b_we && b_addr == 0) nst = nst & ~int'(b_wdata);
        if (e_un) nst |= 'h40;
        if (e_mf) nst |= 'h02;
        if (e_ov) nst |= 'h01;
        if (rxf) nst |= 'h20;
        if (int'(rx_lvl) >= m_rxthr) nst |= 'h10;
        if (txf) nst |= 'h08;
        if (int'(tx_lvl) < m_txthr) nst |= 'h04;
        m_status = nst;
      end
      if (b_en && b_we) begin
        case (b_addr)
          3'd1: m_mask = m_mask | int'(b_wdata);
          3'd2: m_mask = m_mask & ~int'(b_wdata);
          3'd4: m_txthr = int'(b_wdata[OCC_W-1:0]);
          3'd5: m_rxthr = int'(b_wdata[OCC_W-1:0]);
          default: ;
        endcase
      end
    end
  end

  function automatic int model_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_status;
      3'd3: return m_mask;
      3'd4: return m_txthr;
      3'd5: return m_rxthr;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  bit irq_chk_on = 0;
  always @(negedge clk) begin
    if (irq_chk_on) chk(irq == m_irq[0], "R8 per-cycle irq", int'(irq), m_irq);
  end

  task automatic cyc();
    @(negedge clk);
    b_en = 0; b_we = 0; e_un = 0; e_ov = 0; e_mf = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) cyc();
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    cyc();
    b_en = 1; b_we = 1; b_addr = a; b_wdata = BUS_W'(d);
  endtask

  task automatic rd(input logic [2:0] a, input string tag, input int lit);
    int exp;
    cyc();
    b_en = 1; b_we = 0; b_addr = a;
    #1;
    exp = model_rd(a);
    chk(int'(rdata) == exp, tag, int'(rdata), exp);
    if (lit >= 0) chk(int'(rdata) == lit, tag, int'(rdata), lit);
  endtask

  task automatic pulse(input bit u, input bit o, input bit m);
    cyc();
    e_un = u; e_ov = o; e_mf = m;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(irq == 1'b0, "R1 irq in reset", int'(irq), 0);
    arst_n = 1'b1;
    idle(4);
    irq_chk_on = 1;
    rd(3'd4, "R1 tx threshold reset", 1);
    rd(3'd5, "R1 rx threshold reset", 1);
    rd(3'd3, "R1 mask reset", 0);
    // tx 0 < 1 -> bit2 ; rx 0 < 1
    rd(3'd0, "R4 tx room at reset levels", 'h04);

    cyc(); rx_lvl = 3;
    rd(3'd0, "R4 rx avail above thr", 'h14);
    wr(3'd5, 4);
    rd(3'd5, "R4 rx threshold write", 4);
    rd(3'd0, "R4 rx below thr", 'h04);
    cyc(); rx_lvl = 4;
    rd(3'd0, "R4 rx equal thr sets", 'h14);
    cyc(); tx_lvl = 3;
    wr(3'd4, 3);
    idle(1);
    rd(3'd0, "R4 tx equal thr clears", 'h10);
    cyc(); tx_lvl = 2;
    rd(3'd0, "R4 tx below thr sets", 'h14);

    cyc(); rxf = 1; txf = 1;
    rd(3'd0, "R3 full flags", 'h3C);
    cyc(); rxf = 0; txf = 0;
    rd(3'd0, "R3 full flags drop", 'h14);

    pulse(1, 0, 0);
    idle(2);
    rd(3'd0, "R2 underflow sticky", 'h54);
    rd(3'd0, "R5 read cleared sticky", 'h14);

    pulse(1, 1, 1);
    wr(3'd0, 'h02);
    rd(3'd0, "R6 write-one-clear", 'h55);
    rd(3'd0, "R5 cleared after read", 'h14);

    // event in the same cycle as read-clear
    cyc();
    b_en = 1; b_we = 0; b_addr = 3'd0; e_ov = 1;
    #1 chk(int'(rdata) == 'h14, "R10 read value", int'(rdata), 'h14);
    rd(3'd0, "R10 event kept over read-clear", 'h15);
    pulse(0, 0, 1);
    wr(3'd0, 'h02);
    cyc(); e_mf = 1; b_en = 1; b_we = 1; b_addr = 3'd0; b_wdata = 'h02;
    rd(3'd0, "R10 event kept over write-clear", 'h16);

    wr(3'd1, 'h41);
    rd(3'd3, "R7 mask set", 'h41);
    wr(3'd2, 'h01);
    rd(3'd3, "R7 mask clear", 'h40);
    wr(3'd3, 'h7F);
    rd(3'd3, "R7 mask not writable", 'h40);
    rd(3'd1, "R7 set reg reads zero", 0);
    rd(3'd2, "R7 clr reg reads zero", 0);

    pulse(1, 0, 0);
    cyc();
    chk(irq == 1'b0, "R8 irq not yet", int'(irq), 0);
    cyc();
    chk(irq == 1'b1, "R8 irq one clock after status", int'(irq), 1);
    wr(3'd0, 'h40);
    idle(2);
    chk(irq == 1'b0, "R8 irq dropped after clear", int'(irq), 0);
    wr(3'd1, 'h04);
    idle(2);
    chk(irq == 1'b1, "R8 irq from level bit", int'(irq), 1);
    cyc(); tx_lvl = 5;
    idle(2);
    chk(irq == 1'b0, "R8 irq level bit gone", int'(irq), 0);

    cyc(); lin = 1;
    cyc(); tx_lvl = 0;
    pulse(1, 1, 0);
    rd(3'd0, "R9 frozen status", 'h10);
    rd(3'd0, "R9 frozen read does not clear", 'h10);
    wr(3'd5, 2);
    rd(3'd5, "R9 threshold write while frozen", 2);
    chk(irq == 1'b0, "R9 irq frozen", int'(irq), 0);
    cyc(); lin = 0;
    rd(3'd0, "R9 events dropped after freeze", 'h14);
    idle(1);
    chk(irq == 1'b1, "R9 irq resumes", int'(irq), 1);
    idle(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule